// File: doc/BRIEF.md
# Direct-Sequence Symbol-to-Chip Spreader

This block turns a stream of payload bytes into the serial chip stream used by 2.4 GHz direct-sequence spreading. Every accepted byte is cut into two 4-bit symbols, and the low symbol goes out first. Each symbol is replaced by one of sixteen fixed 32-chip pseudorandom codes. The chips leave one at a time, and the output moves on by one chip for each pulse of a chip-rate enable. At the nominal 2 Mchip/s rate one symbol lasts 16 µs.

Bytes enter through a valid/ready handshake into a one-entry holding register. The spreader asks for the next byte only once the second symbol of the current byte has begun. A byte offered at any time during that second symbol follows on with no gap. If nothing is waiting when a byte ends, the chip output drops to zero and an underrun flag is raised. A flag marks the first chip of every symbol, so a downstream modulator can align to symbol boundaries.

Top module: `dsss_chip_spreader`

## Requirements
- R1: After reset, chip_out, sym_start and underrun are 0 and byte_ready is 1.
- R2: Each byte is sent as two symbols of exactly 32 chips each. The low nibble (bits 3:0) goes first and the high nibble (bits 7:4) second.
- R3: Symbol 0 is the chip sequence 11011001110000110101001000101110. It is written with chip 0 on the left, and chip 0 goes out first.
- R4: For symbols 1 to 7, chip i of symbol k equals chip ((i - 4k) mod 32) of symbol 0.
- R5: For symbols 8 to 15, chip i of symbol k equals chip i of symbol k-8, inverted when i is odd.
- R6: chip_out, sym_start and underrun change only on a clock edge where chip_en is 1.
- R7: sym_start is 1 exactly while chip 0 of a symbol is on chip_out, and 0 otherwise.
- R8: While the first symbol of a byte is being sent, byte_ready is 0. From the first chip of the second symbol it is 1 until a byte is accepted. A stored byte holds byte_ready at 0 until that byte starts.
- R9: A byte accepted before the final chip-enable of the previous byte's second symbol starts with its chip 0 on that enable, with no idle chip and no underrun.
- R10: When a byte ends and no byte is waiting, the next chip-enable sets underrun to 1 and forces chip_out and sym_start to 0. Underrun stays 1 until a new byte starts, and clears on that byte's first chip.
- R11: From idle, a stored byte starts on the first chip-enable edge after the edge that accepted it. Its chip 0 and sym_start then appear together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_data | input | 8 | Payload byte |
| byte_valid | input | 1 | byte_data is offered |
| byte_ready | output | 1 | The spreader takes a byte on this edge if byte_valid is 1 |
| chip_en | input | 1 | Chip-rate enable; each 1 moves the output on by one chip |
| chip_out | output | 1 | Current chip (0 while idle) |
| sym_start | output | 1 | chip_out holds chip 0 of a symbol |
| underrun | output | 1 | The stream ran dry at a byte boundary |

## Verification
The hardest case to reach is a byte handed over at the last possible moment. In that case the offer falls between the second-to-last and the last chip-enable of the outgoing byte, so the holding register fills only one edge before the boundary. To reach it, the stimulus walks the offer point through every one of the 32 chip positions of the second symbol while streaming all 256 byte values back to back. The spacing between chip-enables also varies, which shows that the output holds still between enables. The stream then runs dry on purpose to reach underrun. A late byte restarts it from idle, and the bench confirms that the byte waits for an enable before it starts.

// File: rtl/dsss_spread_pkg.sv
package dsss_spread_pkg;

    localparam int CHIP_COUNT = 32;
    localparam int SYM_W      = 4;
    localparam int SYM_COUNT  = 1 << SYM_W;
    localparam int BYTE_W     = 2 * SYM_W;
    localparam int CNT_W      = $clog2(CHIP_COUNT);
    localparam int SHIFT_STEP = 4;
    localparam int HALF_SYMS  = SYM_COUNT / 2;

    typedef struct packed {
        logic                   active;
        logic                   upper;
        logic [CNT_W-1:0]       idx;
        logic [CHIP_COUNT-1:0]  shreg;
        logic [SYM_W-1:0]       hi_sym;
        logic                   underrun;
    } seq_state_t;

    typedef struct packed {
        logic              full;
        logic [BYTE_W-1:0] data;
    } hold_state_t;

    // Code of symbol sym, derived from the symbol-0 code (bit i = chip i):
    // rotate by SHIFT_STEP chips per step, invert odd chips in the upper half.
    function automatic logic [CHIP_COUNT-1:0] spread_code(
        input logic [CHIP_COUNT-1:0] base,
        input int unsigned           sym
    );
        logic [CHIP_COUNT-1:0] code;
        int unsigned           rot;
        logic                  inv;
        rot = SHIFT_STEP * (sym % HALF_SYMS);
        inv = (sym >= HALF_SYMS);
        for (int unsigned i = 0; i < CHIP_COUNT; i++) begin
            code[i] = base[CNT_W'((i + CHIP_COUNT - rot) % CHIP_COUNT)]
                      ^ (inv && (i % 2 == 1));
        end
        return code;
    endfunction

endpackage

// File: rtl/dsss_code_table.sv
module dsss_code_table
    import dsss_spread_pkg::*;
#(
    parameter logic [CHIP_COUNT-1:0] BASE_CODE = 32'h744A_C39B
) (
    input  logic [SYM_W-1:0]      sym,
    output logic [CHIP_COUNT-1:0] code
);

    logic [CHIP_COUNT-1:0] codes [SYM_COUNT];

    for (genvar g = 0; g < SYM_COUNT; g++) begin : g_code
        assign codes[g] = spread_code(BASE_CODE, g);
    end

    assign code = codes[sym];

endmodule

// File: rtl/dsss_byte_hold.sv
module dsss_byte_hold
    import dsss_spread_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              allow,
    input  logic              pop,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data
);

    hold_state_t hold_d, hold_q;
    logic        push;

    always_comb begin
        hold_d   = hold_q;
        in_ready = !hold_q.full && allow;
        push     = in_valid && in_ready;
        if (push) begin
            hold_d.full = 1'b1;
            hold_d.data = in_data;
        end else if (pop) begin
            hold_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign out_valid = hold_q.full;
    assign out_data  = hold_q.data;

endmodule

// File: rtl/dsss_chip_spreader.sv
module dsss_chip_spreader
    import dsss_spread_pkg::*;
#(
    parameter logic [CHIP_COUNT-1:0] BASE_CODE = 32'h744A_C39B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              byte_valid,
    output logic              byte_ready,
    input  logic              chip_en,
    output logic              chip_out,
    output logic              sym_start,
    output logic              underrun
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CHIP_COUNT - 1);

    seq_state_t            st_d, st_q;
    logic                  pop;
    logic                  allow;
    logic                  held_valid;
    logic [BYTE_W-1:0]     held_data;
    logic [SYM_W-1:0]      lookup_sym;
    logic [CHIP_COUNT-1:0] lookup_code;
    logic                  last_chip;

    // A new byte may be requested once its predecessor's upper symbol runs.
    assign allow = !st_q.active || st_q.upper;

    dsss_byte_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (byte_data),
        .in_valid  (byte_valid),
        .in_ready  (byte_ready),
        .allow     (allow),
        .pop       (pop),
        .out_valid (held_valid),
        .out_data  (held_data)
    );

    // Next symbol to load: upper nibble of the running byte, else a new byte.
    assign lookup_sym = (st_q.active && !st_q.upper) ? st_q.hi_sym
                                                     : held_data[SYM_W-1:0];

    dsss_code_table #(
        .BASE_CODE (BASE_CODE)
    ) u_table (
        .sym  (lookup_sym),
        .code (lookup_code)
    );

    assign last_chip = (st_q.idx == LAST_IDX);

    always_comb begin
        st_d = st_q;
        pop  = 1'b0;
        if (chip_en) begin
            if (st_q.active && !last_chip) begin
                st_d.idx   = st_q.idx + CNT_W'(1);
                st_d.shreg = st_q.shreg >> 1;
            end else if (st_q.active && !st_q.upper) begin
                st_d.upper = 1'b1;
                st_d.idx   = '0;
                st_d.shreg = lookup_code;
            end else if (held_valid) begin
                pop           = 1'b1;
                st_d.active   = 1'b1;
                st_d.upper    = 1'b0;
                st_d.idx      = '0;
                st_d.shreg    = lookup_code;
                st_d.hi_sym   = held_data[BYTE_W-1:SYM_W];
                st_d.underrun = 1'b0;
            end else if (st_q.active) begin
                st_d.active   = 1'b0;
                st_d.upper    = 1'b0;
                st_d.idx      = '0;
                st_d.shreg    = '0;
                st_d.underrun = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign chip_out  = st_q.active & st_q.shreg[0];
    assign sym_start = st_q.active && (st_q.idx == '0);
    assign underrun  = st_q.underrun;

endmodule

// File: rtl/dsss_chip_spreader_chk.sv
module dsss_chip_spreader_chk (
    input logic clk,
    input logic rst_n,
    input logic byte_valid,
    input logic byte_ready,
    input logic chip_en,
    input logic chip_out,
    input logic sym_start,
    input logic underrun
);

    logic [5:0] span_q;
    logic       seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            span_q <= '0;
            seen_q <= 1'b0;
        end else if (chip_en) begin
            if (sym_start) begin
                span_q <= 6'd1;
                seen_q <= 1'b1;
            end else if (span_q != 6'd63) begin
                span_q <= span_q + 6'd1;
            end
        end
    end

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |=> ($stable(chip_out) && $stable(sym_start) && $stable(underrun))); // R6
    AST_QUIET_ON_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (!chip_out && !sym_start)); // R10
    AST_UNDERRUN_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> $past(chip_en)); // R10
    AST_ONE_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_ready) |=> !byte_ready); // R8
    AST_START_ONE_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_start && chip_en) |=> !sym_start); // R7
    AST_SYMBOL_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_start && seen_q) |-> (span_q >= 6'd32)); // R2

endmodule

bind dsss_chip_spreader dsss_chip_spreader_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .byte_ready (byte_ready),
    .chip_en    (chip_en),
    .chip_out   (chip_out),
    .sym_start  (sym_start),
    .underrun   (underrun)
);

// File: tb/dsss_chip_spreader_tb.sv
module dsss_chip_spreader_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] byte_data = '0;
    logic       byte_valid = 1'b0;
    logic       byte_ready;
    logic       chip_en = 1'b0;
    logic       chip_out;
    logic       sym_start;
    logic       underrun;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;
    string base_chips = "11011001110000110101001000101110";

    always #10 clk = ~clk;

    dsss_chip_spreader u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_data  (byte_data),
        .byte_valid (byte_valid),
        .byte_ready (byte_ready),
        .chip_en    (chip_en),
        .chip_out   (chip_out),
        .sym_start  (sym_start),
        .underrun   (underrun)
    );

    function automatic logic exp_chip(input int sym, input int i);
        int   src;
        logic c;
        src = (i - 4 * (sym % 8) + 32) % 32;
        c = (base_chips[src] == "1");
        if (sym >= 8 && (i % 2 == 1)) c = !c;
        return c;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    // One chip-enable pulse, then gap quiet cycles checked for stability.
    task automatic tick(input int gap);
        logic c, s, u;
        @(negedge clk) chip_en = 1'b1;
        @(negedge clk) chip_en = 1'b0;
        c = chip_out; s = sym_start; u = underrun;
        for (int k = 0; k < gap; k++) begin
            @(negedge clk);
            chk("R6 chip_out", chip_out, c);
            chk("R6 sym_start", sym_start, s);
            chk("R6 underrun", underrun, u);
        end
    endtask

    task automatic offer(input logic [7:0] v);
        @(negedge clk);
        chk("R8 ready before offer", byte_ready, 1'b1);
        byte_valid = 1'b1;
        byte_data  = v;
        @(negedge clk);
        byte_valid = 1'b0;
        chk("R8 ready after accept", byte_ready, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 chip_out", chip_out, 1'b0);
        chk("R1 sym_start", sym_start, 1'b0);
        chk("R1 underrun", underrun, 1'b0);
        chk("R1 byte_ready", byte_ready, 1'b1);

        // All 256 byte values back to back; offer point sweeps 0..31.
        offer(8'd0);
        for (int b = 0; b < 256; b++) begin
            bit offered;
            offered = 1'b0;
            for (int h = 0; h < 2; h++) begin
                int sym;
                sym = (h == 1) ? ((b >> 4) & 15) : (b & 15);
                for (int i = 0; i < 32; i++) begin
                    tick(b % 3);
                    if (sym == 0)     chk("R2 R3 chip", chip_out, exp_chip(sym, i));
                    else if (sym < 8) chk("R2 R4 chip", chip_out, exp_chip(sym, i));
                    else              chk("R2 R5 chip", chip_out, exp_chip(sym, i));
                    chk("R7 sym_start", sym_start, (i == 0));
                    chk("R9 no underrun", underrun, 1'b0);
                    chk("R8 byte_ready", byte_ready, (h == 1) && !offered);
                    if (h == 1 && i == (b % 32) && b < 255) begin
                        offer(8'(b + 1));
                        offered = 1'b1;
                    end
                end
            end
        end

        // Stream runs dry.
        tick(0);
        chk("R10 underrun set", underrun, 1'b1);
        chk("R10 chip_out idle", chip_out, 1'b0);
        chk("R10 sym_start idle", sym_start, 1'b0);
        chk("R8 ready when idle", byte_ready, 1'b1);
        for (int k = 0; k < 3; k++) begin
            tick(1);
            chk("R10 stays idle", chip_out, 1'b0);
            chk("R10 underrun held", underrun, 1'b1);
        end

        // Restart from idle.
        offer(8'hA5);
        repeat (3) @(negedge clk);
        chk("R10 underrun until start", underrun, 1'b1);
        chk("R11 no start without tick", sym_start, 1'b0);
        chk("R11 chip idle before tick", chip_out, 1'b0);
        tick(0);
        chk("R11 start flag", sym_start, 1'b1);
        chk("R10 underrun cleared", underrun, 1'b0);
        chk("R11 first chip", chip_out, exp_chip(5, 0));
        for (int n = 1; n < 64; n++) begin
            tick(1);
            chk("R2 restart chip", chip_out, exp_chip((n < 32) ? 5 : 10, n % 32));
        end
        tick(0);
        chk("R10 underrun again", underrun, 1'b1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule